// File: doc/BRIEF.md
# Indexed-Port Host Register Interface

This block sits between a slow parallel I/O bus and a chip's internal register space. The host sees only a handful of byte ports, selected by the three low address lines under an active-low chip select. One port holds an internal index, another is a data window onto whatever that index points at, and two more are drop-in targets for boot progress codes. The bus strobes are brought into the system clock domain. Each access takes effect on the falling edge of its strobe as seen after synchronisation.

Accesses through the data window go to one of three places. Index values in the lowest 32 locations go to a local 32-byte store of boot progress codes, which has its own read pointer. Index 49h is served locally as an identity byte. Every other index becomes a one-cycle read or write on a generic internal register bus. After a data-window access the index moves on or stays put, depending on its region. The block also recognises two ways of requesting a complete reset: holding both strobes low while the chip is not selected, and writing a trigger bit at index 49h.

Top module: `idx_host_port`

## Requirements
- R1: After reset the captured read byte is 00h, the index is 00h, and the internal bus strobes, overflow pulse and reset pulse are all low.
- R2: Port 5 writes load the index from data bits 6:0. Port 5 reads return the serial-busy input in bit 7 and the index in bits 6:0. Bit 7 of a write is discarded.
- R3: Writes to port 0 or port 4 append bytes to the 32-entry code store in arrival order. A port 5 write of a value below 20h loads the store's read pointer. Port 6 accesses in that region use and advance the read pointer, and the index itself does not change.
- R4: The code store read pointer stops advancing at 1Fh. Further port 6 accesses keep reading or overwriting entry 1Fh.
- R5: Once 32 codes are held, a further port 0 or port 4 write is dropped, and the overflow output goes high for exactly one cycle. The stored codes stay unchanged.
- R6: Index values 60h to 7Fh reach the internal bus as the value minus 40h. Each port 6 access there advances the index by one, but not past 7Fh.
- R7: Index values 20h to 3Fh reach the internal bus unchanged, and port 6 accesses there leave the index unchanged.
- R8: A port 6 access at index 41h, 43h or 45h advances the index to 42h, 44h or 46h. Other values in 40h to 5Fh are left unchanged.
- R9: A port 6 read at index 49h returns 1 in bits 7 and 6, 0 in bits 5 to 1, and the external identity input in bit 0. It raises no internal bus read and leaves the index unchanged.
- R10: A port 6 write at index 49h with data bit 5 set produces a one-cycle full-reset pulse. It also returns the index, both code store pointers and the captured read byte to their reset values.
- R11: When both strobes are low with chip select high for at least the overlap window (50 ns, rounded up to whole clock cycles), one full-reset pulse is produced with the same effect as R10. A shorter overlap has no effect.
- R12: Strobes with chip select high, and accesses to ports 1, 2, 3 and 7, change no state and raise no internal bus write. Reads of those ports return 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Bus chip select, active low |
| rd_n | input | 1 | Bus read strobe, active low |
| wr_n | input | 1 | Bus write strobe, active low |
| port_sel | input | 3 | Low address lines selecting the port |
| host_wdata | input | 8 | Bus write data |
| host_rdata | output | 8 | Byte captured by the last read access |
| serial_busy | input | 1 | High while the serial-bus slave is mid-transfer |
| ext_id_bit | input | 1 | External level reported in bit 0 of index 49h |
| rb_addr | output | 7 | Internal register bus address |
| rb_wr | output | 1 | Internal bus write strobe, one cycle |
| rb_rd | output | 1 | Internal bus read strobe, one cycle |
| rb_wdata | output | 8 | Internal bus write data |
| rb_rdata | input | 8 | Internal bus read data, valid in the strobe cycle |
| post_ovf | output | 1 | One-cycle pulse when a code write finds the store full |
| full_rst | output | 1 | One-cycle request to reset the whole device |

## Verification
The case that is hardest to reach from the ports is code store overflow. The bench has to fill all 32 entries through the code ports before the 33rd write can show the drop and the one-cycle pulse. So it continues from the codes left by the vector table, writes exactly the remaining count, checks that no pulse has appeared yet, and then adds one more. The reset overlap needs similar care. The bench holds both strobes low with chip select high for two lengths, one on each side of the rounded cycle window, and reads the index back after each.

// File: rtl/ihr_pkg.sv
package ihr_pkg;
   localparam int DW         = 8;
   localparam int AW         = 7;
   localparam int CODE_DEPTH = 32;

   localparam logic [2:0] PORT_CODE_A = 3'd0;
   localparam logic [2:0] PORT_CODE_B = 3'd4;
   localparam logic [2:0] PORT_INDEX  = 3'd5;
   localparam logic [2:0] PORT_DATA   = 3'd6;

   localparam logic [AW-1:0] ID_INDEX   = 7'h49;
   localparam int            ID_RST_BIT = 5;

   typedef enum logic [1:0] {
      RG_CODE   = 2'd0,
      RG_BASE   = 2'd1,
      RG_CTRL   = 2'd2,
      RG_MIRROR = 2'd3
   } region_e;

   function automatic region_e region_of(input logic [AW-1:0] a);
      return region_e'(a[AW-1:AW-2]);
   endfunction

   function automatic logic pair_step(input logic [AW-1:0] a);
      return (a == 7'h41) || (a == 7'h43) || (a == 7'h45);
   endfunction
endpackage

// File: rtl/ihr_strobe_front.sv
module ihr_strobe_front #(
   parameter int SYNC_STAGES = 2,
   parameter int OVL_CYC     = 13
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic rd_n,
   input  logic wr_n,
   output logic rd_ev,
   output logic wr_ev,
   output logic ovl_hit
);
   localparam int CW = $clog2(OVL_CYC + 1);

   // bit 2: select, bit 1: read, bit 0: write (all active low)
   logic [2:0]    stg [SYNC_STAGES];
   logic [2:0]    prev_q;
   logic [2:0]    cur;
   logic [CW-1:0] ovl_cnt;
   logic          ovl_cond;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < SYNC_STAGES; i++) stg[i] <= 3'b111;
         prev_q <= 3'b111;
      end else begin
         stg[0] <= {cs_n, rd_n, wr_n};
         for (int i = 1; i < SYNC_STAGES; i++) stg[i] <= stg[i-1];
         prev_q <= stg[SYNC_STAGES-1];
      end
   end

   assign cur      = stg[SYNC_STAGES-1];
   assign rd_ev    = ~cur[2] & prev_q[1] & ~cur[1];
   assign wr_ev    = ~cur[2] & prev_q[0] & ~cur[0];
   assign ovl_cond = cur[2] & ~cur[1] & ~cur[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          ovl_cnt <= '0;
      else if (!ovl_cond)                  ovl_cnt <= '0;
      else if (ovl_cnt != CW'(OVL_CYC))    ovl_cnt <= ovl_cnt + CW'(1);
   end

   assign ovl_hit = ovl_cond && (ovl_cnt == CW'(OVL_CYC - 1));

   // R11: one overlap yields one request only
   p_ovl_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ovl_hit |=> !ovl_hit);
endmodule

// File: rtl/ihr_code_store.sv
module ihr_code_store #(
   parameter int DEPTH = 32,
   parameter int DW    = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     srst,
   input  logic                     code_wr,
   input  logic [DW-1:0]            code,
   input  logic                     ptr_ld,
   input  logic [$clog2(DEPTH)-1:0] ptr_val,
   input  logic                     acc_rd,
   input  logic                     acc_wr,
   input  logic [DW-1:0]            acc_data,
   output logic [DW-1:0]            rdata,
   output logic                     ovf
);
   localparam int PW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);

   logic [DW-1:0] mem [DEPTH];
   logic [CW-1:0] wptr;
   logic [PW-1:0] rptr;
   logic          full;

   assign full  = (wptr == CW'(DEPTH));
   assign rdata = mem[rptr];

   always_ff @(posedge clk) begin
      if (!srst) begin
         if (code_wr && !full) mem[wptr[PW-1:0]] <= code;
         else if (acc_wr)      mem[rptr]         <= acc_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         ovf  <= 1'b0;
      end else if (srst) begin
         wptr <= '0;
         rptr <= '0;
         ovf  <= 1'b0;
      end else begin
         ovf <= code_wr && full;
         if (code_wr && !full) wptr <= wptr + CW'(1);
         if (ptr_ld)
            rptr <= ptr_val;
         else if ((acc_rd || acc_wr) && (rptr != PW'(DEPTH - 1)))
            rptr <= rptr + PW'(1);
      end
   end

   p_wptr_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wptr <= CW'(DEPTH));

   p_ovf_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |-> full);

   p_rptr_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((acc_rd || acc_wr) && !ptr_ld && !srst && rptr == PW'(DEPTH - 1))
      |=> rptr == PW'(DEPTH - 1));
endmodule

// File: rtl/ihr_index_ctrl.sv
module ihr_index_ctrl
   import ihr_pkg::*;
(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          srst,
   input  logic          rd_ev,
   input  logic          wr_ev,
   input  logic [2:0]    port,
   input  logic [DW-1:0] wdata,
   input  logic          serial_busy,
   input  logic          id_bit,
   input  logic [DW-1:0] rb_rdata,
   input  logic [DW-1:0] code_rdata,
   output logic [AW-1:0] index_q,
   output logic [AW-1:0] rb_addr,
   output logic          rb_rd,
   output logic          rb_wr,
   output logic [DW-1:0] rb_wdata,
   output logic          code_wr,
   output logic          code_acc_rd,
   output logic          code_acc_wr,
   output logic          ptr_ld,
   output logic          reset_req,
   output logic [DW-1:0] rd_val
);
   region_e rg;
   logic    data_rd, data_wr, acc, is_id, is_local, step;

   assign rg       = region_of(index_q);
   assign data_rd  = rd_ev && (port == PORT_DATA);
   assign data_wr  = wr_ev && (port == PORT_DATA);
   assign acc      = data_rd || data_wr;
   assign is_id    = (index_q == ID_INDEX);
   assign is_local = (rg == RG_CODE) || is_id;

   assign rb_rd    = data_rd && !is_local;
   assign rb_wr    = data_wr && !is_local;
   assign rb_addr  = (rg == RG_MIRROR) ? {1'b0, index_q[AW-2:0]} : index_q;
   assign rb_wdata = wdata;

   assign code_wr     = wr_ev && ((port == PORT_CODE_A) || (port == PORT_CODE_B));
   assign code_acc_rd = data_rd && (rg == RG_CODE);
   assign code_acc_wr = data_wr && (rg == RG_CODE);
   assign ptr_ld      = wr_ev && (port == PORT_INDEX) && (region_of(wdata[AW-1:0]) == RG_CODE);
   assign reset_req   = data_wr && is_id && wdata[ID_RST_BIT];

   assign step = ((rg == RG_MIRROR) && (index_q != '1)) || pair_step(index_q);

   always_comb begin
      rd_val = '0;
      if (port == PORT_INDEX)
         rd_val = {serial_busy, index_q};
      else if (port == PORT_DATA) begin
         if (rg == RG_CODE) rd_val = code_rdata;
         else if (is_id)    rd_val = {2'b11, 5'b00000, id_bit};
         else               rd_val = rb_rdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             index_q <= '0;
      else if (srst)                          index_q <= '0;
      else if (wr_ev && port == PORT_INDEX)   index_q <= wdata[AW-1:0];
      else if (acc && step)                   index_q <= index_q + AW'(1);
   end

   p_mirror_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && index_q == 7'h7F) |=> index_q == 7'h7F);

   p_base_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && rg == RG_BASE) |=> $stable(index_q));

   p_pair_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && pair_step(index_q)) |=> index_q == $past(index_q) + AW'(1));

   p_id_local_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && is_id) |-> (!rb_rd && !rb_wr));

   p_bus_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({rb_rd, rb_wr, code_wr}) <= 1);
endmodule

// File: rtl/idx_host_port.sv
module idx_host_port
   import ihr_pkg::*;
#(
   parameter int CLK_PS      = 4000,
   parameter int OVL_PS      = 50000,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_n,
   input  logic       rd_n,
   input  logic       wr_n,
   input  logic [2:0] port_sel,
   input  logic [7:0] host_wdata,
   output logic [7:0] host_rdata,
   input  logic       serial_busy,
   input  logic       ext_id_bit,
   output logic [6:0] rb_addr,
   output logic       rb_wr,
   output logic       rb_rd,
   output logic [7:0] rb_wdata,
   input  logic [7:0] rb_rdata,
   output logic       post_ovf,
   output logic       full_rst
);
   localparam int OVL_CYC = (OVL_PS + CLK_PS - 1) / CLK_PS;
   localparam int PW      = $clog2(CODE_DEPTH);

   logic          rd_ev, wr_ev, ovl_hit, reset_req, srst;
   logic          code_wr, code_acc_rd, code_acc_wr, ptr_ld;
   logic [DW-1:0] code_rdata, rd_val;
   logic [AW-1:0] index_q;

   ihr_strobe_front #(.SYNC_STAGES(SYNC_STAGES), .OVL_CYC(OVL_CYC)) u_front (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
      .rd_ev(rd_ev), .wr_ev(wr_ev), .ovl_hit(ovl_hit)
   );

   ihr_index_ctrl u_idx (
      .clk(clk), .rst_n(rst_n), .srst(srst), .rd_ev(rd_ev), .wr_ev(wr_ev),
      .port(port_sel), .wdata(host_wdata), .serial_busy(serial_busy),
      .id_bit(ext_id_bit), .rb_rdata(rb_rdata), .code_rdata(code_rdata),
      .index_q(index_q), .rb_addr(rb_addr), .rb_rd(rb_rd), .rb_wr(rb_wr),
      .rb_wdata(rb_wdata), .code_wr(code_wr), .code_acc_rd(code_acc_rd),
      .code_acc_wr(code_acc_wr), .ptr_ld(ptr_ld), .reset_req(reset_req),
      .rd_val(rd_val)
   );

   ihr_code_store #(.DEPTH(CODE_DEPTH), .DW(DW)) u_codes (
      .clk(clk), .rst_n(rst_n), .srst(srst), .code_wr(code_wr),
      .code(host_wdata), .ptr_ld(ptr_ld), .ptr_val(host_wdata[PW-1:0]),
      .acc_rd(code_acc_rd), .acc_wr(code_acc_wr), .acc_data(host_wdata),
      .rdata(code_rdata), .ovf(post_ovf)
   );

   assign srst = ovl_hit || reset_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_rst   <= 1'b0;
         host_rdata <= '0;
      end else begin
         full_rst <= srst;
         if (srst)       host_rdata <= '0;
         else if (rd_ev) host_rdata <= rd_val;
      end
   end

   p_rst_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      full_rst |=> !full_rst);

   p_rst_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      full_rst |-> (index_q == '0 && host_rdata == '0));
endmodule

// File: tb/sim_idx_host_port.sv
`timescale 1ns/1ps
module sim_idx_host_port;
   logic       clk = 1'b0;
   logic       rst_n, cs_n, rd_n, wr_n, serial_busy, ext_id_bit;
   logic [2:0] port_sel;
   logic [7:0] host_wdata, host_rdata, rb_wdata, rb_rdata;
   logic [6:0] rb_addr;
   logic       rb_wr, rb_rd, post_ovf, full_rst;

   always #2 clk = ~clk;

   assign rb_rdata = {1'b0, rb_addr} ^ 8'h5A;

   idx_host_port u0 (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
      .port_sel(port_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .serial_busy(serial_busy), .ext_id_bit(ext_id_bit), .rb_addr(rb_addr),
      .rb_wr(rb_wr), .rb_rd(rb_rd), .rb_wdata(rb_wdata), .rb_rdata(rb_rdata),
      .post_ovf(post_ovf), .full_rst(full_rst)
   );

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;
   int rst_pulses = 0, ovf_cycles = 0, rbw_cnt = 0, rbr_cnt = 0;
   logic [6:0] rbw_addr = '0;
   logic [7:0] rbw_data = '0;

   always @(posedge clk) begin
      if (rst_n) begin
         if (full_rst) rst_pulses++;
         if (post_ovf) ovf_cycles++;
         if (rb_rd)    rbr_cnt++;
         if (rb_wr) begin
            rbw_cnt++;
            rbw_addr = rb_addr;
            rbw_data = rb_wdata;
         end
      end
   end

   // {is_read, port, data, expected}
   localparam int NV = 30;
   localparam logic [19:0] VEC [NV] = '{
      {1'b0, 3'd5, 8'h00, 8'h00},   // R3 load pointer 0
      {1'b0, 3'd0, 8'h11, 8'h00},   // R3 code
      {1'b0, 3'd4, 8'h22, 8'h00},   // R3 code
      {1'b0, 3'd0, 8'h33, 8'h00},   // R3 code
      {1'b1, 3'd6, 8'h00, 8'h11},   // R3
      {1'b1, 3'd6, 8'h00, 8'h22},   // R3
      {1'b1, 3'd6, 8'h00, 8'h33},   // R3
      {1'b1, 3'd5, 8'h00, 8'h00},   // R3 index untouched
      {1'b0, 3'd5, 8'h22, 8'h00},   // R7
      {1'b1, 3'd6, 8'h00, 8'h78},   // R7
      {1'b1, 3'd6, 8'h00, 8'h78},   // R7
      {1'b1, 3'd5, 8'h00, 8'h22},   // R7 no step
      {1'b0, 3'd5, 8'h7E, 8'h00},   // R6
      {1'b1, 3'd6, 8'h00, 8'h64},   // R6 maps 3E
      {1'b1, 3'd6, 8'h00, 8'h65},   // R6 maps 3F
      {1'b1, 3'd6, 8'h00, 8'h65},   // R6 stays at 7F
      {1'b1, 3'd5, 8'h00, 8'h7F},   // R6
      {1'b0, 3'd5, 8'h41, 8'h00},   // R8
      {1'b1, 3'd6, 8'h00, 8'h1B},   // R8
      {1'b1, 3'd5, 8'h00, 8'h42},   // R8 stepped
      {1'b1, 3'd6, 8'h00, 8'h18},   // R8
      {1'b1, 3'd5, 8'h00, 8'h42},   // R8 no step at 42
      {1'b0, 3'd5, 8'h45, 8'h00},   // R8
      {1'b0, 3'd6, 8'h99, 8'h00},   // R8 write steps
      {1'b1, 3'd5, 8'h00, 8'h46},   // R8
      {1'b0, 3'd5, 8'h49, 8'h00},   // R9
      {1'b1, 3'd6, 8'h00, 8'hC1},   // R9 identity byte
      {1'b1, 3'd5, 8'h00, 8'h49},   // R9 no step
      {1'b0, 3'd5, 8'hF3, 8'h00},   // R2 bit 7 dropped
      {1'b1, 3'd5, 8'h00, 8'h73}    // R2
   };

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic chk_n(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_wr(input logic [2:0] p, input logic [7:0] d);
      @(negedge clk);
      port_sel = p; host_wdata = d; cs_n = 1'b0;
      idle(1); wr_n = 1'b0; idle(4); wr_n = 1'b1; idle(3); cs_n = 1'b1; idle(2);
   endtask

   task automatic bus_rd(input logic [2:0] p, output logic [7:0] d);
      @(negedge clk);
      port_sel = p; cs_n = 1'b0;
      idle(1); rd_n = 1'b0; idle(5); d = host_rdata;
      rd_n = 1'b1; idle(3); cs_n = 1'b1; idle(2);
   endtask

   task automatic overlap(input int n);
      @(negedge clk);
      cs_n = 1'b1; rd_n = 1'b0; wr_n = 1'b0;
      idle(n); rd_n = 1'b1; wr_n = 1'b1; idle(6);
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      int base_cnt;
      rst_n = 1'b0; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
      port_sel = 3'd0; host_wdata = 8'h00; serial_busy = 1'b0; ext_id_bit = 1'b1;
      idle(5); rst_n = 1'b1; idle(3);

      // R1 reset state
      chk("R1 rdata", host_rdata, 8'h00);
      chk("R1 strobes", {4'b0, rb_rd, rb_wr, post_ovf, full_rst}, 8'h00);
      bus_rd(3'd5, d); chk("R1 index", d, 8'h00);

      for (int i = 0; i < NV; i++) begin
         logic [19:0] v;
         v = VEC[i];
         if (v[19]) begin
            bus_rd(v[18:16], d);
            chk($sformatf("table row %0d", i), d, v[7:0]);
         end else
            bus_wr(v[18:16], v[15:8]);
      end
      // R8 the 45h write reached the internal bus
      chk("R8 rb waddr", {1'b0, rbw_addr}, 8'h45);
      chk("R8 rb wdata", rbw_data, 8'h99);

      // R9 identity read raises no internal read
      bus_wr(3'd5, 8'h49);
      base_cnt = rbr_cnt;
      bus_rd(3'd6, d);
      chk_n("R9 no rb read", rbr_cnt, base_cnt);
      bus_wr(3'd5, 8'h73);

      // R2 busy bit
      serial_busy = 1'b1;
      bus_rd(3'd5, d); chk("R2 busy", d, 8'hF3);
      serial_busy = 1'b0;

      // R12 deselected strobe and unused ports
      base_cnt = rbw_cnt;
      @(negedge clk); port_sel = 3'd5; host_wdata = 8'h11; cs_n = 1'b1;
      wr_n = 1'b0; idle(4); wr_n = 1'b1; idle(4);
      bus_wr(3'd7, 8'h22);
      bus_wr(3'd1, 8'h33);
      bus_rd(3'd5, d); chk("R12 index kept", d, 8'h73);
      chk_n("R12 no rb write", rbw_cnt, base_cnt);
      bus_rd(3'd2, d); chk("R12 unused port read", d, 8'h00);

      // R4 pointer stops at 1Fh
      bus_wr(3'd5, 8'h1E);
      bus_wr(3'd6, 8'hAA);
      bus_wr(3'd6, 8'hBB);
      bus_wr(3'd6, 8'hCC);
      bus_wr(3'd5, 8'h1E);
      bus_rd(3'd6, d); chk("R4 entry 1E", d, 8'hAA);
      bus_rd(3'd6, d); chk("R4 entry 1F", d, 8'hCC);
      bus_rd(3'd6, d); chk("R4 held at 1F", d, 8'hCC);

      // R5 fill the remaining 29 entries, then overflow
      for (int i = 3; i < 32; i++) bus_wr((i % 2 == 0) ? 3'd0 : 3'd4, 8'h40 + 8'(i));
      chk_n("R5 no early ovf", ovf_cycles, 0);
      bus_wr(3'd0, 8'hEE);
      chk_n("R5 ovf pulse", ovf_cycles, 1);
      bus_wr(3'd5, 8'h1F);
      bus_rd(3'd6, d); chk("R5 last entry kept", d, 8'h5F);
      bus_wr(3'd5, 8'h03);
      bus_rd(3'd6, d); chk("R5 entry 03", d, 8'h43);

      // R6 mirror write reaches bus at minus 40h
      bus_wr(3'd5, 8'h6A);
      bus_wr(3'd6, 8'h77);
      chk("R6 rb waddr", {1'b0, rbw_addr}, 8'h2A);
      chk("R6 rb wdata", rbw_data, 8'h77);

      // R11 short then long overlap
      overlap(8);
      chk_n("R11 short overlap", rst_pulses, 0);
      bus_rd(3'd5, d); chk("R11 index after short", d, 8'h6B);
      overlap(20);
      chk_n("R11 long overlap", rst_pulses, 1);
      bus_rd(3'd5, d); chk("R11 index cleared", d, 8'h00);

      // R10 trigger bit at 49h
      bus_wr(3'd5, 8'h33);
      bus_wr(3'd5, 8'h49);
      bus_wr(3'd6, 8'h20);
      chk_n("R10 reset pulse", rst_pulses, 2);
      chk("R10 rdata cleared", host_rdata, 8'h00);
      bus_rd(3'd5, d); chk("R10 index cleared", d, 8'h00);
      bus_wr(3'd0, 8'h5D);
      bus_wr(3'd5, 8'h00);
      bus_rd(3'd6, d); chk("R10 write pointer restarted", d, 8'h5D);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule